// File: doc/BRIEF.md
# PLL Control Register Unit with Feed-Locked Commit

This unit sits on a simple register bus and owns the control and configuration of a PLL. Software writes an enable bit, a connect bit, a multiplier select and a divider select into staging registers. None of these writes reaches the PLL directly. The staged values are copied into the effective registers that drive the PLL only when an unlock pair is written to a dedicated feed address. The pair is the key byte 0xAA, followed in the very next clock cycle by the key byte 0x55.

A power-down request clears the effective enable and connect state. After wakeup, that state stays cleared until software runs a new unlock pair. The connect output to the clock mux is asserted only when the PLL is effectively enabled, effectively connected and reports lock. The unit does not decide when enabling and connecting are safe. A single unlock that turns on both is carried out as programmed, and software is responsible for the enable, wait-for-lock, connect order.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, `pll_en_o`, `pll_conn_o`, `pll_m_o` and `pll_p_o` are all zero.
- R2: Writes to CTRL (address 0) and CFG (address 1) change only the staging registers. The PLL outputs keep their values until an unlock pair completes. A write to the read-only status address (2) changes no state.
- R3: A feed-address (3) write of 0xAA (wdata[7:0]), followed in the next clock cycle by a feed write of 0x55, commits every staged field. The effective outputs show the new values from the clock edge that accepts the 0x55 write.
- R4: If the second feed value is anything other than 0x55, nothing is committed.
- R5: An unlock pair fails and commits nothing if any cycle falls between its two writes, whether that cycle is an idle cycle or another bus access.
- R6: Writing the keys in reverse order (0x55 then 0xAA) commits nothing.
- R7: While `pd_i` is high, the effective enable and connect bits are cleared from the next edge on. The effective multiplier and divider are kept.
- R8: After `pd_i` falls, the effective enable and connect bits stay cleared until a new unlock pair completes.
- R9: If power-down and a completing unlock fall in the same cycle, power-down wins for enable and connect. Multiplier and divider are still committed.
- R10: `pll_conn_o` equals effective enable AND effective connect AND `lock_i`. A single unlock with both CTRL bits staged commits both bits.
- R11: Field layout. CTRL: bit0 enable, bit1 connect. CFG: bits[4:0] M, bits[6:5] P. Reads of CTRL and CFG return the staged values. Status (address 2) reads bit0 effective enable, bit1 effective connect, bits[6:2] effective M, bits[8:7] effective P and bit9 the live `lock_i`. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A bus access takes place this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| pd_i | input | 1 | Power-down request |
| lock_i | input | 1 | PLL lock indication |
| pll_en_o | output | 1 | Effective PLL enable |
| pll_conn_o | output | 1 | Connect to clock mux, gated by lock |
| pll_m_o | output | 5 | Effective multiplier select |
| pll_p_o | output | 2 | Effective divider select |

## Verification
The commit of an unlock pair and the power-down clear both update the effective registers, and they can land in the same cycle. The bench provokes the collision by raising `pd_i` at the same falling edge that drives the 0x55 feed write, with new multiplier and divider values already staged. It then expects enable and connect to read as cleared while M and P take the staged values. A related race, lock arriving against an already committed connect, is judged by toggling `lock_i` and watching `pll_conn_o` follow it with no clock edge in between.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_FEED = 2'd3
  } reg_sel_e;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/pll_bus_decode.sv
module pll_bus_decode
  import pll_feed_pkg::*;
(
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wbyte_i,
  output logic              wr_ctrl_o,
  output logic              wr_cfg_o,
  output logic              key_a_o,
  output logic              key_b_o
);
  logic wr;
  assign wr        = valid_i & we_i;
  assign wr_ctrl_o = wr & (addr_i == REG_CTRL);
  assign wr_cfg_o  = wr & (addr_i == REG_CFG);
  assign key_a_o   = wr & (addr_i == REG_FEED) & (wbyte_i == KEY_FIRST);
  assign key_b_o   = wr & (addr_i == REG_FEED) & (wbyte_i == KEY_SECOND);
endmodule

// File: rtl/pll_feed_seq.sv
module pll_feed_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_a_i,
  input  logic key_b_i,
  output logic commit_o
);
  logic armed_q;
  // any cycle other than a first-key write disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= key_a_i;
  end
  assign commit_o = armed_q & key_b_i;
endmodule

// File: rtl/pll_commit_regs.sv
module pll_commit_regs #(
  parameter int unsigned M_W = 5,
  parameter int unsigned P_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ctrl_i,
  input  logic               wr_cfg_i,
  input  logic [M_W+P_W-1:0] wdata_i,
  input  logic               commit_i,
  input  logic               pd_i,
  output logic               sh_en_o,
  output logic               sh_conn_o,
  output logic [M_W-1:0]     sh_m_o,
  output logic [P_W-1:0]     sh_p_o,
  output logic               ef_en_o,
  output logic               ef_conn_o,
  output logic [M_W-1:0]     ef_m_o,
  output logic [P_W-1:0]     ef_p_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_en_o   <= 1'b0;
      sh_conn_o <= 1'b0;
      sh_m_o    <= '0;
      sh_p_o    <= '0;
    end else begin
      if (wr_ctrl_i) begin
        sh_en_o   <= wdata_i[0];
        sh_conn_o <= wdata_i[1];
      end
      if (wr_cfg_i) begin
        sh_m_o <= wdata_i[M_W-1:0];
        sh_p_o <= wdata_i[M_W+P_W-1:M_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ef_en_o   <= 1'b0;
      ef_conn_o <= 1'b0;
      ef_m_o    <= '0;
      ef_p_o    <= '0;
    end else begin
      if (commit_i) begin
        ef_m_o <= sh_m_o;
        ef_p_o <= sh_p_o;
      end
      // power-down overrides a same-cycle commit of the control bits
      if (pd_i) begin
        ef_en_o   <= 1'b0;
        ef_conn_o <= 1'b0;
      end else if (commit_i) begin
        ef_en_o   <= sh_en_o;
        ef_conn_o <= sh_conn_o;
      end
    end
  end
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pll_feed_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned M_W    = 5,
  parameter int unsigned P_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              pd_i,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic              pll_conn_o,
  output logic [M_W-1:0]    pll_m_o,
  output logic [P_W-1:0]    pll_p_o
);
  localparam int unsigned CFG_W  = M_W + P_W;
  localparam int unsigned LOCK_B = 2 + CFG_W;

  logic wr_ctrl, wr_cfg, key_a, key_b, commit_w;
  logic sh_en, sh_conn;
  logic [M_W-1:0] sh_m;
  logic [P_W-1:0] sh_p;
  logic ef_en, ef_conn;
  logic unused_hi;

  assign unused_hi = ^bus_wdata_i[DATA_W-1:8];

  pll_bus_decode u_dec (
    .valid_i  (bus_valid_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wbyte_i  (bus_wdata_i[7:0]),
    .wr_ctrl_o(wr_ctrl),
    .wr_cfg_o (wr_cfg),
    .key_a_o  (key_a),
    .key_b_o  (key_b)
  );

  pll_feed_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_a_i (key_a),
    .key_b_i (key_b),
    .commit_o(commit_w)
  );

  pll_commit_regs #(.M_W(M_W), .P_W(P_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ctrl_i(wr_ctrl),
    .wr_cfg_i (wr_cfg),
    .wdata_i  (bus_wdata_i[CFG_W-1:0]),
    .commit_i (commit_w),
    .pd_i     (pd_i),
    .sh_en_o  (sh_en),
    .sh_conn_o(sh_conn),
    .sh_m_o   (sh_m),
    .sh_p_o   (sh_p),
    .ef_en_o  (ef_en),
    .ef_conn_o(ef_conn),
    .ef_m_o   (pll_m_o),
    .ef_p_o   (pll_p_o)
  );

  assign pll_en_o   = ef_en;
  assign pll_conn_o = ef_en & ef_conn & lock_i;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      REG_CTRL: begin
        bus_rdata_o[0] = sh_en;
        bus_rdata_o[1] = sh_conn;
      end
      REG_CFG:  bus_rdata_o[CFG_W-1:0] = {sh_p, sh_m};
      REG_STAT: begin
        bus_rdata_o[0]          = ef_en;
        bus_rdata_o[1]          = ef_conn;
        bus_rdata_o[LOCK_B-1:2] = {pll_p_o, pll_m_o};
        bus_rdata_o[LOCK_B]     = lock_i;
      end
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pll_feed_chk.sv
module pll_feed_chk
  import pll_feed_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned M_W    = 5,
  parameter int unsigned P_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              pd_i,
  input logic              lock_i,
  input logic              pll_en_o,
  input logic              pll_conn_o,
  input logic [M_W-1:0]    pll_m_o,
  input logic [P_W-1:0]    pll_p_o,
  input logic              commit_w,
  input logic              sh_en
);
  logic key_a_seen;
  assign key_a_seen = bus_valid_i & bus_we_i & (bus_addr_i == REG_FEED)
                    & (bus_wdata_i[7:0] == KEY_FIRST);

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> ($stable(pll_m_o) && $stable(pll_p_o)));
  // R3
  commit_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_w && !pd_i) |=> (pll_en_o == $past(sh_en)));
  // R5
  key_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |-> $past(key_a_seen));
  // R7
  pd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!pll_en_o && !pll_conn_o));
  // R8
  stay_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_en_o && !commit_w) |=> !pll_en_o);
  // R10
  conn_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_conn_o |-> (pll_en_o && lock_i));
endmodule

bind pll_feed_regs pll_feed_chk #(.DATA_W(DATA_W), .M_W(M_W), .P_W(P_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .pd_i       (pd_i),
  .lock_i     (lock_i),
  .pll_en_o   (pll_en_o),
  .pll_conn_o (pll_conn_o),
  .pll_m_o    (pll_m_o),
  .pll_p_o    (pll_p_o),
  .commit_w   (commit_w),
  .sh_en      (sh_en)
);

// File: tb/pll_feed_regs_tb_top.sv
module pll_feed_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0, pd = 1'b0, lock = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        en_o, conn_o;
  logic [4:0]  m_o;
  logic [1:0]  p_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_feed_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pd_i(pd), .lock_i(lock), .pll_en_o(en_o), .pll_conn_o(conn_o),
    .pll_m_o(m_o), .pll_p_o(p_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each call occupies one clock: drive at negedge, return at next negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
  endtask
  task automatic idle();
    valid = 1'b0; we = 1'b0; wdata = '0;
    @(negedge clk);
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    valid = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    valid = 1'b0;
  endtask
  task automatic feed();
    wr(2'd3, 32'hAA); wr(2'd3, 32'h55); idle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 en", {31'd0, en_o}, 0);
    check("R1 conn", {31'd0, conn_o}, 0);
    check("R1 m/p", {25'd0, p_o, m_o}, 0);
    rd(2'd2, d); check("R1 status", d, 0);
  endtask

  task automatic t_staged();
    logic [31:0] d;
    wr(2'd0, 32'h3); wr(2'd1, 32'd73); idle();
    check("R2 outputs held", {23'd0, en_o, conn_o, p_o, m_o}, 0);
    rd(2'd0, d); check("R11 ctrl readback", d, 3);
    rd(2'd1, d); check("R11 cfg readback", d, 73);
    wr(2'd2, 32'h3FF); idle();
    rd(2'd2, d); check("R2 status write ignored", d, 0);
  endtask

  task automatic t_valid();
    logic [31:0] d;
    wr(2'd0, 32'h1); feed();
    check("R3 en", {31'd0, en_o}, 1);
    check("R3 m", {27'd0, m_o}, 9);
    check("R3 p", {30'd0, p_o}, 2);
    check("R10 conn off w/o connect", {31'd0, conn_o}, 0);
    rd(2'd2, d); check("R11 status", d, 293);
  endtask

  task automatic t_wrong();
    wr(2'd1, 32'd35);
    wr(2'd3, 32'hAA); wr(2'd3, 32'h56); idle();
    check("R4 wrong key m", {27'd0, m_o}, 9);
  endtask

  task automatic t_gap();
    wr(2'd3, 32'hAA); idle(); wr(2'd3, 32'h55); idle();
    check("R5 idle gap m", {27'd0, m_o}, 9);
    wr(2'd3, 32'hAA); wr(2'd1, 32'd35); wr(2'd3, 32'h55); idle();
    check("R5 bus gap m", {27'd0, m_o}, 9);
  endtask

  task automatic t_order();
    wr(2'd3, 32'h55); wr(2'd3, 32'hAA); idle();
    check("R6 reverse m", {27'd0, m_o}, 9);
    feed();
    check("R3 staged kept m", {27'd0, m_o}, 3);
    check("R3 staged kept p", {30'd0, p_o}, 1);
  endtask

  task automatic t_both();
    logic [31:0] d;
    lock = 1'b0;
    wr(2'd0, 32'h3); feed();
    check("R10 en both", {31'd0, en_o}, 1);
    check("R10 conn no lock", {31'd0, conn_o}, 0);
    rd(2'd2, d); check("R10 eff conn bit", {31'd0, d[1]}, 1);
    lock = 1'b1; #1;
    check("R10 conn with lock", {31'd0, conn_o}, 1);
    rd(2'd2, d); check("R11 lock bit", {31'd0, d[9]}, 1);
    lock = 1'b0; #1;
    check("R10 conn lock lost", {31'd0, conn_o}, 0);
  endtask

  task automatic t_pd();
    lock = 1'b1;
    pd = 1'b1; @(negedge clk);
    check("R7 en cleared", {31'd0, en_o}, 0);
    check("R7 conn cleared", {31'd0, conn_o}, 0);
    check("R7 m kept", {27'd0, m_o}, 3);
    @(negedge clk); pd = 1'b0;
    idle(); idle();
    check("R8 en stays off", {31'd0, en_o}, 0);
    check("R8 conn stays off", {31'd0, conn_o}, 0);
    feed();
    check("R8 refeed en", {31'd0, en_o}, 1);
    check("R8 refeed conn", {31'd0, conn_o}, 1);
  endtask

  task automatic t_collide();
    wr(2'd1, 32'd103);
    wr(2'd3, 32'hAA);
    pd = 1'b1; wr(2'd3, 32'h55);
    pd = 1'b0; idle();
    check("R9 en pd wins", {31'd0, en_o}, 0);
    check("R9 conn pd wins", {31'd0, conn_o}, 0);
    check("R9 m committed", {27'd0, m_o}, 7);
    check("R9 p committed", {30'd0, p_o}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_staged(); t_valid(); t_wrong(); t_gap();
    t_order(); t_both(); t_pd(); t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule